// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the register-access side of a platform interrupt controller. It takes single 32-bit requests from a simple valid/ready bus. Each request is decoded against four address windows: per-source priority words, a read-only view of the pending bits, per-context enable bitmaps, and per-context control words. The base address of each window is a parameter. The enable and control windows repeat once per context, at a power-of-two stride.

The block holds the priority, enable and threshold registers and drives them out in flat form to a separate arbiter. The arbiter returns, for each context, the best source id it could hand out. The front end turns a read of a context's claim word into a one-cycle claim strobe toward the arbiter. A write of the same word becomes a one-cycle completion strobe. The read data, an error flag or both come back on a response channel. That channel holds its value until the requester accepts it, and the claim is made only once per request however long the response waits.

Top module: `intc_reg_frontend`

## Requirements
- R1: An access whose address has bit 1 or bit 0 set is rejected. It returns read data 0 with the error flag set and changes no register.
- R2: An aligned address outside every window returns data 0 with the error flag set, and a write to it changes nothing.
- R3: In the priority window, source id = (byte offset / 4) + 1, so offset 0 holds source 1 and the window is NUM_SRC words long. A write keeps only the low PRIO_W bits of the data, and a read returns them zero-extended.
- R4: In the pending window, word w bit b reads as the pending state of source 32*w+b, where input bit k is source k+1 and source 0 always reads 0. A write there sets the error flag and has no effect.
- R5: In the enable window, context = offset / ENA_STRIDE and word = (offset mod ENA_STRIDE) / 4. Each word is a plain 32-bit read/write register, where bit b of word w enables source 32*w+b. A word index of (NUM_SRC+32)/32 or more is an error and is not stored.
- R6: In the control window, context = offset / CTX_STRIDE, and the in-context offset selects the register: 0 is the threshold and 4 is claim/complete. Any other offset is an error. A threshold write larger than MAX_PRIO is dropped without an error.
- R7: A read of offset 4 returns the arbiter's best id for that context. When that id is nonzero, the read raises claim_valid for exactly one cycle with the context and id; a zero id raises no strobe.
- R8: A write of offset 4 whose data is in 1..NUM_SRC raises complete_valid for one cycle with the context and the id. Any other value is dropped without an error.
- R9: Each request gets exactly one response. bus_rvalid rises the cycle after the request is taken, and data and error stay stable until bus_rready is seen. Writes respond with data 0.
- R10: After reset all priorities, enables and thresholds are 0 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request present; held until its response is accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rready | input | 1 | Requester accepts the response |
| bus_rvalid | output | 1 | Response present |
| bus_rdata | output | 32 | Read data (0 for writes and errors) |
| bus_err | output | 1 | Access was misaligned, unmapped or illegal |
| pend_in | input | NUM_SRC | Pending flags, bit k is source k+1 |
| best_id_in | input | NUM_CTX*SRC_W | Best claimable id per context, from the arbiter |
| prio_out | output | NUM_SRC*PRIO_W | Source priorities, source 1 in the low field |
| enable_out | output | NUM_CTX*NWORDS*32 | Enable words, context-major |
| thresh_out | output | NUM_CTX*PRIO_W | Per-context thresholds |
| claim_valid | output | 1 | One-cycle claim strobe |
| claim_ctx | output | CTX_W | Context making the claim |
| claim_id | output | SRC_W | Id being claimed |
| complete_valid | output | 1 | One-cycle completion strobe |
| complete_ctx | output | CTX_W | Context completing |
| complete_id | output | SRC_W | Id being completed |

## Verification
Some properties are checked by assertions on every cycle. A claim strobe is never followed by a second one in the next cycle, and its id is the value the response then carries. A held response keeps its data and error flag stable. An error response always carries zero data. A completion id is always in range, and every stored threshold stays within MAX_PRIO. Other behaviour can only be shown by bench scenarios. These include the address arithmetic at each window edge, the masking of priority data, the dropping of oversized thresholds and out-of-range completions, and the fact that rejected writes leave every register untouched.

// File: rtl/intc_fe_pkg.sv
package intc_fe_pkg;
   typedef enum logic [2:0] {
      KIND_NONE,
      KIND_PRIO,
      KIND_PEND,
      KIND_ENA,
      KIND_THR,
      KIND_CLAIM
   } reg_kind_e;

   typedef enum logic {ST_IDLE, ST_RESP} fe_state_e;

   function automatic bit is_pow2(input longint v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // 32-bit words needed to hold one bit for sources 0..nsrc
   function automatic int words_for(input int nsrc);
      return (nsrc + 32) / 32;
   endfunction
endpackage

// File: rtl/intc_fe_decode.sv
module intc_fe_decode import intc_fe_pkg::*; #(
   parameter int          NUM_SRC    = 40,
   parameter int          NUM_CTX    = 2,
   parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
   parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
   parameter logic [31:0] ENA_BASE   = 32'h0000_2000,
   parameter logic [31:0] ENA_STRIDE = 32'h0000_0080,
   parameter logic [31:0] CTX_BASE   = 32'h0020_0000,
   parameter logic [31:0] CTX_STRIDE = 32'h0000_1000,
   localparam int NWORDS = words_for(NUM_SRC),
   localparam int SRC_W  = $clog2(NUM_SRC + 1),
   localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int WRD_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic [31:0]      addr,
   output reg_kind_e        kind,
   output logic [SRC_W-1:0] src,
   output logic [CTX_W-1:0] ctx,
   output logic [WRD_W-1:0] word
);
   localparam logic [31:0] PRIO_SPAN = 32'(NUM_SRC * 4);
   localparam logic [31:0] PEND_SPAN = 32'(NWORDS * 4);
   localparam logic [31:0] ENA_SPAN  = 32'(NUM_CTX) * ENA_STRIDE;
   localparam logic [31:0] CTX_SPAN  = 32'(NUM_CTX) * CTX_STRIDE;
   localparam int          ENA_SH    = $clog2(ENA_STRIDE);
   localparam int          CTX_SH    = $clog2(CTX_STRIDE);

   logic [31:0] off_pr, off_pe, off_en, off_cx, in_en, in_cx;

   always_comb begin
      off_pr = addr - PRIO_BASE;
      off_pe = addr - PEND_BASE;
      off_en = addr - ENA_BASE;
      off_cx = addr - CTX_BASE;
      in_en  = off_en & (ENA_STRIDE - 32'd1);
      in_cx  = off_cx & (CTX_STRIDE - 32'd1);
      kind   = KIND_NONE;
      src    = '0;
      ctx    = '0;
      word   = '0;
      if (addr[1:0] != 2'b00) begin
         kind = KIND_NONE;
      end else if (addr >= PRIO_BASE && off_pr < PRIO_SPAN) begin
         kind = KIND_PRIO;
         src  = SRC_W'(off_pr[31:2] + 30'd1);
      end else if (addr >= PEND_BASE && off_pe < PEND_SPAN) begin
         kind = KIND_PEND;
         word = WRD_W'(off_pe[31:2]);
      end else if (addr >= ENA_BASE && off_en < ENA_SPAN) begin
         ctx = CTX_W'(off_en >> ENA_SH);
         if (in_en[31:2] < 30'(NWORDS)) begin
            kind = KIND_ENA;
            word = WRD_W'(in_en[31:2]);
         end
      end else if (addr >= CTX_BASE && off_cx < CTX_SPAN) begin
         ctx = CTX_W'(off_cx >> CTX_SH);
         if (in_cx == 32'd0)      kind = KIND_THR;
         else if (in_cx == 32'd4) kind = KIND_CLAIM;
      end
   end
endmodule

// File: rtl/intc_fe_store.sv
module intc_fe_store import intc_fe_pkg::*; #(
   parameter int NUM_SRC = 40,
   parameter int NUM_CTX = 2,
   parameter int PRIO_W  = 3,
   localparam int NWORDS = words_for(NUM_SRC),
   localparam int SRC_W  = $clog2(NUM_SRC + 1),
   localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int WRD_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_prio,
   input  logic                          wr_ena,
   input  logic                          wr_thr,
   input  logic [SRC_W-1:0]              src,
   input  logic [CTX_W-1:0]              ctx,
   input  logic [WRD_W-1:0]              word,
   input  logic [31:0]                   wdata,
   output logic [NUM_SRC*PRIO_W-1:0]     prio_flat,
   output logic [NUM_CTX*NWORDS*32-1:0]  ena_flat,
   output logic [NUM_CTX*PRIO_W-1:0]     thr_flat
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_flat[s*PRIO_W +: PRIO_W] <= '0;
         else if (wr_prio && src == SRC_W'(s + 1))
            prio_flat[s*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
      end
   end

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            thr_flat[c*PRIO_W +: PRIO_W] <= '0;
         else if (wr_thr && ctx == CTX_W'(c))
            thr_flat[c*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
      end
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ena_flat[(c*NWORDS+w)*32 +: 32] <= '0;
            else if (wr_ena && ctx == CTX_W'(c) && word == WRD_W'(w))
               ena_flat[(c*NWORDS+w)*32 +: 32] <= wdata;
         end
      end
   end
endmodule

// File: rtl/intc_reg_frontend.sv
module intc_reg_frontend import intc_fe_pkg::*; #(
   parameter int          NUM_SRC    = 40,
   parameter int          NUM_CTX    = 2,
   parameter int          PRIO_W     = 3,
   parameter int          MAX_PRIO   = 7,
   parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
   parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
   parameter logic [31:0] ENA_BASE   = 32'h0000_2000,
   parameter logic [31:0] ENA_STRIDE = 32'h0000_0080,
   parameter logic [31:0] CTX_BASE   = 32'h0020_0000,
   parameter logic [31:0] CTX_STRIDE = 32'h0000_1000,
   localparam int NWORDS = words_for(NUM_SRC),
   localparam int SRC_W  = $clog2(NUM_SRC + 1),
   localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   localparam int WRD_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_valid,
   input  logic                          bus_write,
   input  logic [31:0]                   bus_addr,
   input  logic [31:0]                   bus_wdata,
   input  logic                          bus_rready,
   output logic                          bus_rvalid,
   output logic [31:0]                   bus_rdata,
   output logic                          bus_err,
   input  logic [NUM_SRC-1:0]            pend_in,
   input  logic [NUM_CTX*SRC_W-1:0]      best_id_in,
   output logic [NUM_SRC*PRIO_W-1:0]     prio_out,
   output logic [NUM_CTX*NWORDS*32-1:0]  enable_out,
   output logic [NUM_CTX*PRIO_W-1:0]     thresh_out,
   output logic                          claim_valid,
   output logic [CTX_W-1:0]              claim_ctx,
   output logic [SRC_W-1:0]              claim_id,
   output logic                          complete_valid,
   output logic [CTX_W-1:0]              complete_ctx,
   output logic [SRC_W-1:0]              complete_id
);
   if (NUM_SRC < 1 || NUM_CTX < 1)
      $fatal(1, "intc_reg_frontend: need at least one source and one context");
   if (PRIO_W < 1 || PRIO_W > 32 || MAX_PRIO >= (1 << PRIO_W))
      $fatal(1, "intc_reg_frontend: MAX_PRIO does not fit PRIO_W");
   if (!is_pow2(ENA_STRIDE) || ENA_STRIDE < 32'(NWORDS * 4))
      $fatal(1, "intc_reg_frontend: enable stride must be a power of two holding all words");
   if (!is_pow2(CTX_STRIDE) || CTX_STRIDE < 32'd8)
      $fatal(1, "intc_reg_frontend: context stride must be a power of two of at least 8");

   reg_kind_e        kind;
   logic [SRC_W-1:0] src;
   logic [CTX_W-1:0] ctx;
   logic [WRD_W-1:0] word;

   intc_fe_decode #(
      .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
      .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
      .ENA_BASE(ENA_BASE), .ENA_STRIDE(ENA_STRIDE),
      .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
   ) i_decode (
      .addr(bus_addr), .kind(kind), .src(src), .ctx(ctx), .word(word)
   );

   fe_state_e state_q;
   logic      take;
   logic      acc_err;
   logic      thr_ok;
   logic      id_ok;
   logic [31:0] rd_val;
   logic [SRC_W-1:0] best_sel;
   logic [NWORDS*32-1:0] pend_pad;

   assign take   = (state_q == ST_IDLE) && bus_valid;
   assign thr_ok = bus_wdata <= 32'(MAX_PRIO);
   assign id_ok  = (bus_wdata != 32'd0) && (bus_wdata <= 32'(NUM_SRC));
   assign acc_err = (kind == KIND_NONE) || (bus_write && kind == KIND_PEND);

   intc_fe_store #(
      .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)
   ) i_store (
      .clk(clk), .rst_n(rst_n),
      .wr_prio(take && bus_write && kind == KIND_PRIO),
      .wr_ena (take && bus_write && kind == KIND_ENA),
      .wr_thr (take && bus_write && kind == KIND_THR && thr_ok),
      .src(src), .ctx(ctx), .word(word), .wdata(bus_wdata),
      .prio_flat(prio_out), .ena_flat(enable_out), .thr_flat(thresh_out)
   );

   always_comb begin
      pend_pad = '0;
      pend_pad[NUM_SRC:1] = pend_in;
   end

   assign best_sel = best_id_in[int'(ctx)*SRC_W +: SRC_W];

   always_comb begin
      rd_val = '0;
      unique case (kind)
         KIND_PRIO:  rd_val[PRIO_W-1:0] = prio_out[(int'(src) - 1)*PRIO_W +: PRIO_W];
         KIND_PEND:  rd_val = pend_pad[int'(word)*32 +: 32];
         KIND_ENA:   rd_val = enable_out[(int'(ctx)*NWORDS + int'(word))*32 +: 32];
         KIND_THR:   rd_val[PRIO_W-1:0] = thresh_out[int'(ctx)*PRIO_W +: PRIO_W];
         KIND_CLAIM: rd_val[SRC_W-1:0] = best_sel;
         default:    rd_val = '0;
      endcase
   end

   assign claim_valid    = take && !bus_write && kind == KIND_CLAIM && best_sel != '0;
   assign claim_ctx      = ctx;
   assign claim_id       = best_sel;
   assign complete_valid = take && bus_write && kind == KIND_CLAIM && id_ok;
   assign complete_ctx   = ctx;
   assign complete_id    = bus_wdata[SRC_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         bus_rdata <= '0;
         bus_err   <= 1'b0;
      end else if (take) begin
         state_q   <= ST_RESP;
         bus_rdata <= (bus_write || acc_err) ? 32'd0 : rd_val;
         bus_err   <= acc_err;
      end else if (state_q == ST_RESP && bus_rready) begin
         state_q   <= ST_IDLE;
      end
   end

   assign bus_rvalid = (state_q == ST_RESP);
endmodule

// File: rtl/intc_fe_checker.sv
module intc_fe_checker #(
   parameter int NUM_SRC  = 40,
   parameter int NUM_CTX  = 2,
   parameter int PRIO_W   = 3,
   parameter int MAX_PRIO = 7,
   localparam int SRC_W   = $clog2(NUM_SRC + 1)
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_rvalid,
   input logic                      bus_rready,
   input logic [31:0]               bus_rdata,
   input logic                      bus_err,
   input logic                      claim_valid,
   input logic [SRC_W-1:0]          claim_id,
   input logic                      complete_valid,
   input logic [SRC_W-1:0]          complete_id,
   input logic [NUM_CTX*PRIO_W-1:0] thresh_out
);
   AST_CLAIM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      claim_valid |=> !claim_valid); // R7
   AST_CLAIM_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
      claim_valid |=> bus_rvalid && !bus_err && bus_rdata == 32'($past(claim_id))); // R7
   AST_CLAIM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      claim_valid |-> claim_id != '0); // R7
   AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid && !bus_rready |=> bus_rvalid && $stable(bus_rdata) && $stable(bus_err)); // R9
   AST_NO_STROBE_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> !claim_valid && !complete_valid); // R9
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid && bus_err |-> bus_rdata == 32'd0); // R2
   AST_COMPLETE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      complete_valid |-> complete_id != '0 && 32'(complete_id) <= 32'(NUM_SRC)); // R8

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_thr
      AST_THR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
         32'(thresh_out[c*PRIO_W +: PRIO_W]) <= 32'(MAX_PRIO)); // R6
   end
endmodule

bind intc_reg_frontend intc_fe_checker #(
   .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO)
) i_checker (.*);

// File: tb/test_intc_reg_frontend.sv
`timescale 1ns/1ps
module test_intc_reg_frontend;
   localparam int NUM_SRC = 40;
   localparam int NUM_CTX = 2;
   localparam int PRIO_W  = 3;
   localparam int NWORDS  = (NUM_SRC + 32) / 32;
   localparam int SRC_W   = $clog2(NUM_SRC + 1);
   localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_valid = 1'b0, bus_write = 1'b0, bus_rready = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic bus_rvalid, bus_err;
   logic [31:0] bus_rdata;
   logic [NUM_SRC-1:0] pend_in = '0;
   logic [NUM_CTX*SRC_W-1:0] best_id_in = '0;
   logic [NUM_SRC*PRIO_W-1:0] prio_out;
   logic [NUM_CTX*NWORDS*32-1:0] enable_out;
   logic [NUM_CTX*PRIO_W-1:0] thresh_out;
   logic claim_valid, complete_valid;
   logic [CTX_W-1:0] claim_ctx, complete_ctx;
   logic [SRC_W-1:0] claim_id, complete_id;

   always #4 clk = ~clk;

   intc_reg_frontend i_intc_reg_frontend (.*);

   typedef struct {
      logic [31:0] rdata;
      logic        err;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   int checks = 0, errors = 0;
   int claim_cnt = 0, comp_cnt = 0;
   logic [CTX_W-1:0] last_claim_ctx = '0, last_comp_ctx = '0;
   logic [SRC_W-1:0] last_claim_id = '0, last_comp_id = '0;
   bit done = 0;

   // monitor: compare every accepted response with the queued expectation
   always @(negedge clk) begin
      if (bus_rvalid && bus_rready) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected response rdata=%h err=%b exp=none", bus_rdata, bus_err);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (bus_rdata !== e.rdata || bus_err !== e.err) begin
               errors++;
               $display("FAIL %s rdata=%h err=%b exp rdata=%h err=%b",
                        e.tag, bus_rdata, bus_err, e.rdata, e.err);
            end
         end
      end
      if (claim_valid) begin
         claim_cnt++;
         last_claim_ctx = claim_ctx;
         last_claim_id  = claim_id;
      end
      if (complete_valid) begin
         comp_cnt++;
         last_comp_ctx = complete_ctx;
         last_comp_id  = complete_id;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic txn(input logic wr, input logic [31:0] a, input logic [31:0] d,
                      input logic [31:0] er, input logic ee, input int delay, input string tag);
      exp_t e;
      e.rdata = er; e.err = ee; e.tag = tag;
      exp_q.push_back(e);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_rready = 1'b0;
      do begin @(posedge clk); #2; end while (!bus_rvalid);
      for (int i = 0; i < delay; i++) begin @(posedge clk); #2; end
      bus_rready = 1'b1;
      @(posedge clk); #2;
      bus_valid = 1'b0; bus_rready = 1'b0; bus_write = 1'b0;
   endtask

   initial begin
      int c0, k0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;
      // R10 reset state
      check(bus_rvalid == 1'b0, "R10 no response after reset", 128'(bus_rvalid), 0);
      check(prio_out == '0 && thresh_out == '0, "R10 prio/threshold cleared", 128'(prio_out), 0);
      check(enable_out == '0, "R10 enables cleared", 128'(enable_out), 0);
      txn(0, 32'h0, 0, 32'h0, 0, 0, "R10 priority read after reset");

      // R3 priority mapping and masking
      txn(1, 32'h0, 32'hFF, 32'h0, 0, 0, "R3 write source 1");
      txn(0, 32'h0, 0, 32'h7, 0, 2, "R3 source 1 masked to PRIO_W bits");
      check(prio_out[2:0] == 3'd7, "R3 source 1 field", 128'(prio_out[2:0]), 7);
      txn(1, 32'h9C, 32'h5, 32'h0, 0, 0, "R3 write last source");
      txn(0, 32'h9C, 0, 32'h5, 0, 0, "R3 last source readback");
      check(prio_out[39*3 +: 3] == 3'd5, "R3 last source field", 128'(prio_out[39*3 +: 3]), 5);
      txn(0, 32'hA0, 0, 32'h0, 1, 0, "R2 one word past priority window");

      // R4 pending view
      pend_in[4] = 1'b1; pend_in[32] = 1'b1;
      txn(0, 32'h1000, 0, 32'h20, 0, 0, "R4 pending word 0");
      txn(0, 32'h1004, 0, 32'h2, 0, 0, "R4 pending word 1");
      txn(1, 32'h1000, 32'hFFFF_FFFF, 32'h0, 1, 0, "R4 pending write flagged");
      txn(0, 32'h1000, 0, 32'h20, 0, 0, "R4 pending unchanged after write");

      // R5 enables
      txn(1, 32'h2084, 32'hA5A5_0003, 32'h0, 0, 0, "R5 write ctx1 word1");
      txn(0, 32'h2084, 0, 32'hA5A5_0003, 0, 0, "R5 read ctx1 word1");
      check(enable_out[96 +: 32] == 32'hA5A5_0003, "R5 ctx1 word1 output", 128'(enable_out[96 +: 32]), 128'(32'hA5A5_0003));
      txn(1, 32'h2008, 32'hFFFF_FFFF, 32'h0, 1, 0, "R5 word index past end write");
      txn(0, 32'h2008, 0, 32'h0, 1, 0, "R5 word index past end read");
      check(enable_out[95:0] == '0, "R5 rejected write stored nothing", 128'(enable_out[95:0]), 0);

      // R6 thresholds and control offsets
      txn(1, 32'h20_0000, 32'h3, 32'h0, 0, 0, "R6 threshold write ctx0");
      txn(1, 32'h20_0000, 32'h8, 32'h0, 0, 0, "R6 oversized threshold no error");
      txn(0, 32'h20_0000, 0, 32'h3, 0, 0, "R6 oversized threshold dropped");
      txn(1, 32'h20_1000, 32'h7, 32'h0, 0, 0, "R6 threshold at max ctx1");
      txn(0, 32'h20_1000, 0, 32'h7, 0, 0, "R6 threshold at max kept");
      txn(0, 32'h20_0008, 0, 32'h0, 1, 0, "R6 bad in-context offset");

      // R7 claims
      best_id_in = {6'd17, 6'd9};
      c0 = claim_cnt;
      txn(0, 32'h20_1004, 0, 32'd17, 0, 3, "R7 claim ctx1 held response");
      check(claim_cnt == c0 + 1, "R7 one claim per request", 128'(claim_cnt - c0), 1);
      check(last_claim_ctx == 1 && last_claim_id == 17, "R7 claim ctx/id",
            128'({last_claim_ctx, last_claim_id}), 128'({1'b1, 6'd17}));
      txn(0, 32'h20_0004, 0, 32'd9, 0, 0, "R7 claim ctx0");
      check(last_claim_ctx == 0 && last_claim_id == 9, "R7 claim ctx0 id",
            128'({last_claim_ctx, last_claim_id}), 128'({1'b0, 6'd9}));
      best_id_in = '0;
      c0 = claim_cnt;
      txn(0, 32'h20_1004, 0, 32'd0, 0, 0, "R7 claim with nothing eligible");
      check(claim_cnt == c0, "R7 no strobe for zero id", 128'(claim_cnt - c0), 0);

      // R8 completions
      k0 = comp_cnt;
      txn(1, 32'h20_1004, 32'd17, 32'h0, 0, 0, "R8 complete id 17");
      check(comp_cnt == k0 + 1 && last_comp_ctx == 1 && last_comp_id == 17, "R8 completion strobe",
            128'({comp_cnt - k0, 32'(last_comp_id)}), 128'({32'd1, 32'd17}));
      txn(1, 32'h20_1004, 32'd41, 32'h0, 0, 0, "R8 out-of-range id");
      txn(1, 32'h20_0004, 32'd0, 32'h0, 0, 0, "R8 zero id");
      check(comp_cnt == k0 + 1, "R8 out-of-range ids dropped", 128'(comp_cnt - k0), 1);

      // R1 / R2 misaligned and unmapped
      txn(1, 32'h1, 32'h3, 32'h0, 1, 0, "R1 misaligned write");
      txn(0, 32'h0, 0, 32'h7, 0, 0, "R1 misaligned write left source 1");
      txn(0, 32'h2, 0, 32'h0, 1, 1, "R1 misaligned read");
      txn(0, 32'h5000, 0, 32'h0, 1, 0, "R2 unmapped read");
      txn(1, 32'h20_2000, 32'h1, 32'h0, 1, 0, "R2 past last context");
      check(thresh_out == {3'd7, 3'd3}, "R2 rejected writes left thresholds", 128'(thresh_out), 128'({3'd7, 3'd3}));

      @(posedge clk); #2;
      check(exp_q.size() == 0, "R9 every request answered", 128'(exp_q.size()), 0);
      done = 1;
   end

   initial begin
      int n = 0;
      while (!done && n < 200000) begin @(posedge clk); n++; end
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=done", n);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule